// File: doc/BRIEF.md
# Control Transfer Recorder With Branch Stepping

This block watches a stream of retired-instruction events. Each event carries a source address, a destination address and a kind: sequential, branch, interrupt or exception. When recording is on, the block stores the endpoints of the most recent branch in one read-only address pair. It stores the endpoints of the most recent interrupt or exception in a second read-only pair.

The same event stream drives a single-step trap. By default the trap flag raises a trap after every retired instruction. A mode bit in the control register narrows this to taken control transfers only. Once a trap is raised it stays pending until the handler acknowledges it. While it is pending, both address pairs are frozen, so the transfer that caused the trap can still be read.

Four external status pins each show either a performance-monitor signal or a breakpoint-hit signal. Each pin has its own select bit in the control register. Software writes the control register. A write applies to events from the following cycle onward.

The trap sequencer has two states. **ST_IDLE** means no trap is pending. **ST_PENDING** means a step trap is raised. Transition **T_ARM** goes from ST_IDLE to ST_PENDING on a qualifying event. Transition **T_ACK** goes from ST_PENDING to ST_IDLE on an acknowledge. In every other case the state holds: **T_HOLD_IDLE** in ST_IDLE and **T_HOLD_PEND** in ST_PENDING.

Top module: `xfer_trace_unit`

## Requirements
- R1: After reset, all four address registers read 0, the control readback is 0, `step_trap` is 0, and every status pin shows its performance-monitor input.
- R2: A control write stores data bits 5..0, and `ctl_rd_data` returns them zero-extended. Bits 63..6 always read 0, whatever was written.
- R3: A control write affects only events presented in later cycles. An event presented in the same cycle as the write is handled with the old control value.
- R4: When record enable (control bit 0) is 1 and no trap is pending, a valid branch event (kind 2'b01) loads `br_from`/`br_to` at the next edge and leaves the exception pair unchanged.
- R5: Under the same conditions, an interrupt (kind 2'b10) or exception (kind 2'b11) event loads `exc_from`/`exc_to` and leaves the branch pair unchanged.
- R6: A sequential event (kind 2'b00) never changes any address register. Neither does any event while record enable is 0.
- R7: When step mode (control bit 1) is 0 and `trap_flag` is 1, any valid event, sequential included, raises `step_trap` from the next cycle.
- R8: When step mode is 1 and `trap_flag` is 1, only branch, interrupt and exception events raise `step_trap`. Sequential events do not.
- R9: When `trap_flag` is 0, no event raises `step_trap`.
- R10: `step_trap` stays high until a cycle with `trap_ack` high and is low from the next cycle. While it is high, events change no address register.
- R11: `status_pin[i]` equals `bkpt_hit[i]` when control bit 2+i is 1, and `perf_sig[i]` when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 64 | Control write data |
| ctl_rd_data | output | 64 | Control register readback |
| trap_flag | input | 1 | Single-step trap flag |
| ev_valid | input | 1 | Retired-instruction event valid |
| ev_kind | input | 2 | Event kind: 00 sequential, 01 branch, 10 interrupt, 11 exception |
| ev_from | input | 64 | Event source address |
| ev_to | input | 64 | Event destination address |
| trap_ack | input | 1 | Handler acknowledge; clears a pending trap |
| perf_sig | input | 4 | Performance-monitor signal per pin |
| bkpt_hit | input | 4 | Breakpoint-hit signal per pin |
| status_pin | output | 4 | External status pins |
| step_trap | output | 1 | Pending single-step trap |
| br_from | output | 64 | Last branch source address |
| br_to | output | 64 | Last branch destination address |
| exc_from | output | 64 | Last interrupt/exception source address |
| exc_to | output | 64 | Last interrupt/exception destination address |

## Verification
The assertions assume that `ev_kind` is meaningful only while `ev_valid` is high. They also assume that `trap_ack` is raised only by a handler responding to a pending trap, although the sequencer ignores a stray acknowledge. The stimulus holds every input steady from one falling edge to the next and returns strobes to 0 after one cycle. It raises `trap_ack` only after it has seen `step_trap`, except in one case that checks that an acknowledge in the idle state has no effect. Events during a pending trap are sent on purpose, so the freeze and the absence of a second arm are both exercised.

// File: rtl/xtr_pkg.sv
package xtr_pkg;

    typedef enum logic [1:0] {
        KIND_SEQ  = 2'b00,
        KIND_BR   = 2'b01,
        KIND_INTR = 2'b10,
        KIND_EXC  = 2'b11
    } ev_kind_e;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_PENDING = 1'b1
    } step_state_e;

    localparam int unsigned CTL_REC_BIT  = 0;
    localparam int unsigned CTL_STEP_BIT = 1;
    localparam int unsigned CTL_PIN_LSB  = 2;

    function automatic logic is_transfer(input ev_kind_e k);
        return k != KIND_SEQ;
    endfunction

    function automatic logic is_exc_class(input ev_kind_e k);
        return (k == KIND_INTR) || (k == KIND_EXC);
    endfunction

endpackage

// File: rtl/xtr_ctl_reg.sv
module xtr_ctl_reg #(
    parameter int unsigned CTL_W    = 64,
    parameter int unsigned NUM_PINS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CTL_W-1:0]    wr_data,
    output logic [CTL_W-1:0]    rd_data,
    output logic                rec_en,
    output logic                step_xfer,
    output logic [NUM_PINS-1:0] pin_sel
);
    import xtr_pkg::*;

    localparam int unsigned CFG_W = CTL_PIN_LSB + NUM_PINS;

    logic [CFG_W-1:0] cfg_q;
    logic             unused_rsvd;

    assign unused_rsvd = ^wr_data[CTL_W-1:CFG_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= wr_data[CFG_W-1:0];
        end
    end

    always_comb begin
        rd_data            = '0;
        rd_data[CFG_W-1:0] = cfg_q;
    end

    assign rec_en    = cfg_q[CTL_REC_BIT];
    assign step_xfer = cfg_q[CTL_STEP_BIT];
    assign pin_sel   = cfg_q[CFG_W-1:CTL_PIN_LSB];

    // R2: written low field is what reads back next cycle
    assert_ctl_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[CFG_W-1:0] == $past(wr_data[CFG_W-1:0]));

    // R2: without a write the register holds
    assert_ctl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));

endmodule

// File: rtl/xtr_addr_pair.sv
module xtr_addr_pair #(
    parameter int unsigned ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
        end else if (load) begin
            src_q <= src_i;
            dst_q <= dst_i;
        end
    end

    // R6: contents change only through a load
    assert_pair_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(src_q) && $stable(dst_q));

endmodule

// File: rtl/xtr_step_fsm.sv
module xtr_step_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_valid,
    input  logic ev_xfer,
    input  logic trap_flag,
    input  logic step_xfer,
    input  logic trap_ack,
    output logic pending
);
    import xtr_pkg::*;

    step_state_e state_q, state_d;
    logic        qualify;

    // R7/R8/R9: which events arm the trap
    always_comb begin
        qualify = ev_valid && trap_flag && (!step_xfer || ev_xfer);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (qualify)  state_d = ST_PENDING; // T_ARM
            ST_PENDING: if (trap_ack) state_d = ST_IDLE;    // T_ACK
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pending = (state_q == ST_PENDING);
    end

    // R9: arming needs the trap flag on an event
    assert_arm_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(ev_valid && trap_flag));

    // R8: sequential events never arm in transfer-step mode
    assert_xfer_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && step_xfer && !ev_xfer) |=> !pending);

    // R10: trap held until acknowledged, cleared right after
    assert_hold_until_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !trap_ack) |=> pending);
    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && trap_ack) |=> !pending);

endmodule

// File: rtl/xtr_pin_mux.sv
module xtr_pin_mux #(
    parameter int unsigned NUM_PINS = 4
) (
    input  logic [NUM_PINS-1:0] pin_sel,
    input  logic [NUM_PINS-1:0] perf_sig,
    input  logic [NUM_PINS-1:0] bkpt_hit,
    output logic [NUM_PINS-1:0] pin_out
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        assign pin_out[i] = pin_sel[i] ? bkpt_hit[i] : perf_sig[i];
    end

endmodule

// File: rtl/xfer_trace_unit.sv
module xfer_trace_unit #(
    parameter int unsigned ADDR_W   = 64,
    parameter int unsigned CTL_W    = 64,
    parameter int unsigned NUM_PINS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_wr_en,
    input  logic [CTL_W-1:0]    ctl_wr_data,
    output logic [CTL_W-1:0]    ctl_rd_data,
    input  logic                trap_flag,
    input  logic                ev_valid,
    input  logic [1:0]          ev_kind,
    input  logic [ADDR_W-1:0]   ev_from,
    input  logic [ADDR_W-1:0]   ev_to,
    input  logic                trap_ack,
    input  logic [NUM_PINS-1:0] perf_sig,
    input  logic [NUM_PINS-1:0] bkpt_hit,
    output logic [NUM_PINS-1:0] status_pin,
    output logic                step_trap,
    output logic [ADDR_W-1:0]   br_from,
    output logic [ADDR_W-1:0]   br_to,
    output logic [ADDR_W-1:0]   exc_from,
    output logic [ADDR_W-1:0]   exc_to
);
    import xtr_pkg::*;

    ev_kind_e            kind;
    logic                rec_en;
    logic                step_xfer;
    logic [NUM_PINS-1:0] pin_sel;
    logic                pending;
    logic                rec_ok;
    logic                load_br;
    logic                load_exc;

    assign kind = ev_kind_e'(ev_kind);

    xtr_ctl_reg #(.CTL_W(CTL_W), .NUM_PINS(NUM_PINS)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr_en), .wr_data(ctl_wr_data),
        .rd_data(ctl_rd_data), .rec_en(rec_en), .step_xfer(step_xfer),
        .pin_sel(pin_sel)
    );

    xtr_step_fsm u_step (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid),
        .ev_xfer(is_transfer(kind)), .trap_flag(trap_flag),
        .step_xfer(step_xfer), .trap_ack(trap_ack), .pending(pending)
    );

    // R4/R5/R6/R10: recording gated by enable and by a pending trap
    assign rec_ok   = ev_valid && rec_en && !pending;
    assign load_br  = rec_ok && (kind == KIND_BR);
    assign load_exc = rec_ok && is_exc_class(kind);

    xtr_addr_pair #(.ADDR_W(ADDR_W)) u_br_pair (
        .clk(clk), .rst_n(rst_n), .load(load_br), .src_i(ev_from),
        .dst_i(ev_to), .src_q(br_from), .dst_q(br_to)
    );

    xtr_addr_pair #(.ADDR_W(ADDR_W)) u_exc_pair (
        .clk(clk), .rst_n(rst_n), .load(load_exc), .src_i(ev_from),
        .dst_i(ev_to), .src_q(exc_from), .dst_q(exc_to)
    );

    xtr_pin_mux #(.NUM_PINS(NUM_PINS)) u_pins (
        .pin_sel(pin_sel), .perf_sig(perf_sig), .bkpt_hit(bkpt_hit),
        .pin_out(status_pin)
    );

    assign step_trap = pending;

    // R10: a pending trap freezes both pairs
    assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        step_trap |=> $stable(br_from) && $stable(br_to)
                   && $stable(exc_from) && $stable(exc_to));

    // R4: branch capture lands on the branch pair only
    assert_br_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == 2'b01 && ctl_rd_data[0] && !step_trap)
        |=> br_to == $past(ev_to) && br_from == $past(ev_from) && $stable(exc_to));

    // R6: sequential events leave every pair alone
    assert_seq_no_rec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == 2'b00) |=> $stable(br_to) && $stable(exc_to));

    // R2: reserved readback bits are always zero
    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd_data[CTL_W-1:CTL_PIN_LSB+NUM_PINS] == '0);

endmodule

// File: tb/xfer_trace_unit_tb.sv
module xfer_trace_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr_en = 1'b0;
    logic [63:0] ctl_wr_data = '0;
    logic [63:0] ctl_rd_data;
    logic        trap_flag = 1'b0;
    logic        ev_valid = 1'b0;
    logic [1:0]  ev_kind = 2'b00;
    logic [63:0] ev_from = '0;
    logic [63:0] ev_to = '0;
    logic        trap_ack = 1'b0;
    logic [3:0]  perf_sig = 4'b1010;
    logic [3:0]  bkpt_hit = 4'b0101;
    logic [3:0]  status_pin;
    logic        step_trap;
    logic [63:0] br_from, br_to, exc_from, exc_to;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    xfer_trace_unit u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .ctl_rd_data(ctl_rd_data), .trap_flag(trap_flag), .ev_valid(ev_valid),
        .ev_kind(ev_kind), .ev_from(ev_from), .ev_to(ev_to), .trap_ack(trap_ack),
        .perf_sig(perf_sig), .bkpt_hit(bkpt_hit), .status_pin(status_pin),
        .step_trap(step_trap), .br_from(br_from), .br_to(br_to),
        .exc_from(exc_from), .exc_to(exc_to)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_ctl(input logic [63:0] d);
        @(negedge clk); ctl_wr_en = 1'b1; ctl_wr_data = d;
        @(negedge clk); ctl_wr_en = 1'b0; ctl_wr_data = '0;
    endtask

    task automatic send_ev(input logic [1:0] k, input logic [63:0] f, input logic [63:0] t);
        @(negedge clk); ev_valid = 1'b1; ev_kind = k; ev_from = f; ev_to = t;
        @(negedge clk); ev_valid = 1'b0; ev_kind = 2'b00;
    endtask

    task automatic ack();
        @(negedge clk); trap_ack = 1'b1;
        @(negedge clk); trap_ack = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 br_to", br_to, 0);
        check("R1 exc_from", exc_from, 0);
        check("R1 ctl", ctl_rd_data, 0);
        check("R1 trap", {63'd0, step_trap}, 0);
        check("R1 pins", {60'd0, status_pin}, 64'hA);
    endtask

    task automatic t_ctl_rw();
        write_ctl(64'hFFFF_FFFF_FFFF_FFC5);
        check("R2 readback", ctl_rd_data, 64'h05);
        write_ctl(64'h0);
        check("R2 clear", ctl_rd_data, 64'h0);
    endtask

    task automatic t_write_timing();
        // R3: enable arrives with a branch in the same cycle
        @(negedge clk); ctl_wr_en = 1'b1; ctl_wr_data = 64'h1;
        ev_valid = 1'b1; ev_kind = 2'b01; ev_from = 64'h111; ev_to = 64'h222;
        @(negedge clk); ctl_wr_en = 1'b0; ev_valid = 1'b0;
        check("R3 old ctl used", br_to, 0);
        send_ev(2'b01, 64'h111, 64'h222);
        check("R3 new ctl used", br_to, 64'h222);
    endtask

    task automatic t_record();
        send_ev(2'b01, 64'hA000, 64'hB000);
        check("R4 br_from", br_from, 64'hA000);
        check("R4 br_to", br_to, 64'hB000);
        check("R4 exc untouched", exc_to, 0);
        send_ev(2'b10, 64'hC000, 64'hD000);
        check("R5 intr exc_from", exc_from, 64'hC000);
        check("R5 br untouched", br_to, 64'hB000);
        send_ev(2'b11, 64'hE000, 64'hF000);
        check("R5 exc exc_to", exc_to, 64'hF000);
        send_ev(2'b00, 64'h1, 64'h2);
        check("R6 seq br", br_to, 64'hB000);
        check("R6 seq exc", exc_to, 64'hF000);
        write_ctl(64'h0);
        send_ev(2'b01, 64'h5, 64'h6);
        check("R6 disabled br", br_to, 64'hB000);
    endtask

    task automatic t_step();
        trap_flag = 1'b0;
        send_ev(2'b01, 64'h7, 64'h8);
        check("R9 no flag", {63'd0, step_trap}, 0);
        trap_flag = 1'b1;
        ack();
        check("R10 stray ack", {63'd0, step_trap}, 0);
        send_ev(2'b00, 64'h7, 64'h8);
        check("R7 seq arms", {63'd0, step_trap}, 1);
        ack();
        check("R10 ack clears", {63'd0, step_trap}, 0);
        write_ctl(64'h2);
        send_ev(2'b00, 64'h7, 64'h8);
        check("R8 seq no arm", {63'd0, step_trap}, 0);
        send_ev(2'b10, 64'h7, 64'h8);
        check("R8 intr arms", {63'd0, step_trap}, 1);
        ack();
        trap_flag = 1'b0;
    endtask

    task automatic t_freeze();
        write_ctl(64'h1);
        trap_flag = 1'b1;
        send_ev(2'b01, 64'h1000, 64'h2000);
        check("R10 trigger captured", br_to, 64'h2000);
        check("R7 armed", {63'd0, step_trap}, 1);
        send_ev(2'b01, 64'h3000, 64'h4000);
        check("R10 frozen br", br_to, 64'h2000);
        send_ev(2'b11, 64'h3000, 64'h4000);
        check("R10 frozen exc", exc_to, 64'hF000);
        check("R10 still pending", {63'd0, step_trap}, 1);
        trap_flag = 1'b0;
        ack();
        send_ev(2'b01, 64'h3000, 64'h4000);
        check("R10 resumes", br_to, 64'h4000);
    endtask

    task automatic t_pins();
        write_ctl(64'h18);
        #1;
        check("R11 mixed", {60'd0, status_pin}, 64'hC);
        perf_sig = 4'b0000; bkpt_hit = 4'b1111; #1;
        check("R11 swap", {60'd0, status_pin}, 64'h6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctl_rw();
        t_write_timing();
        t_record();
        t_step();
        t_freeze();
        t_pins();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule